// File: doc/BRIEF.md
# Copy-Generation Line Data Encoder

This block produces the 20-bit copy-generation and aspect-ratio identification waveform on one line of each field of 525-line video. A host loads the payload and an enable flag through a small byte-wide write port. When a line-start strobe arrives and the accompanying line number is one of the two target lines (20 in the first field, 283 in the second), the block decides whether that line carries the waveform. That decision is made from the enable flag and payload held at that moment.

On an encoded line, the block first waits a fixed lead-in from the line-start strobe. It then emits 21 equal bit cells as two-level luma codes: a reference cell that is always high, followed by payload bits b1 to b20 in that order. A strobe marks every sample that belongs to the bit train, so that a downstream mixer can replace the picture luma with it. At every other time the luma output rests at black level.

The output is a timed sample stream locked to the pixel clock and cannot be stalled. It therefore has a valid-style insert strobe and no ready input, and applies no back-pressure. The host port is write-only and has no handshake: one write is taken on each clock where the write enable is high.

Top module: `cgms_line_enc`

## Requirements
- R1: After reset the enable flag and the whole payload are zero, so no target line is encoded; `insert` is 0 and `luma` equals the black code (240) until the host sets the enable flag.
- R2: Encoding happens only when `h_ref` is sampled high while `line_num` equals 20 or 283 and the enable flag is set; on any other line `insert` stays 0.
- R3: Take the clock edge that samples `h_ref` high as edge 0, and let p be the value shown after edge p. On an encoded line, `insert` is 1 exactly for p from 302 to 302+21*63-1 (1624): 21 cells of 63 clocks each.
- R4: Cell 0, the first 63 samples of the train, is the reference cell and always carries a logic 1, whatever the payload.
- R5: Cell k (1 to 20) carries payload bit bk. Address 0 holds b8..b1 in data bits 7..0. Address 1 holds b16..b9 in data bits 7..0. Address 2 holds b20..b17 in data bits 7..4 and the enable flag in data bit 0. Address 2 bits 3..1 and all writes to address 3 are ignored.
- R6: While `insert` is 1, a logic 1 is output as code 740 (70 IRE) and a logic 0 as code 240 (black).
- R7: Whenever `insert` is 0, `luma` is the black code 240.
- R8: The payload and the enable flag are captured on the `h_ref` edge of a target line, using the register values from before any write on that same edge. Writes made later during that line affect only the next target line.
- R9: A new `h_ref` ends any train in progress on that edge. The block then decides afresh for the new line.
- R10: Clearing the enable flag stops encoding from the next target line onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (27 MHz) |
| rst_n | input | 1 | Active-low synchronous reset |
| h_ref | input | 1 | One-clock line-start strobe at the sync reference |
| line_num | input | 10 | Line number of the line that `h_ref` starts |
| wr_en | input | 1 | Host register write enable |
| wr_addr | input | 2 | Host register address |
| wr_data | input | 8 | Host register write data |
| insert | output | 1 | High on samples that belong to the bit train |
| luma | output | 10 | Luma code: data level inside the train, black elsewhere |

## Verification
The bench drives a line number with every line strobe and covers both target lines and the lines beside them. A design that decoded the line number off by one would encode line 19 or 21 instead. The bench rewrites the payload in the middle of a train and on the very edge of a line strobe. A design without a line-start shadow copy, or one that let the write reach the shadow on that shared edge, would send a mixed word. Further cases cut a line short with an early strobe, write the ignored address and bits, and use all-ones and all-zeros payloads. Together these expose a train that runs past a new line, a mis-packed b17 to b20 nibble, a missing or inverted reference cell, and an off-by-one lead-in or cell length, any of which shifts every compared sample.

// File: rtl/cgms_pkg.sv
package cgms_pkg;
  // Payload width fixed by the line format: three host bytes, 20 bits used.
  localparam int PAYLOAD_BITS = 20;
  localparam int HOST_AW      = 2;
  localparam int HOST_DW      = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_TRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/cgms_hostregs.sv
module cgms_hostregs
  import cgms_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [HOST_AW-1:0]        wr_addr,
  input  logic [HOST_DW-1:0]        wr_data,
  input  logic                      capture,
  output logic                      live_en,
  output logic [PAYLOAD_BITS-1:0]   shadow
);
  logic [7:0] lo_byte;   // b8..b1
  logic [7:0] mid_byte;  // b16..b9
  logic [3:0] hi_nib;    // b20..b17

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_byte  <= '0;
      mid_byte <= '0;
      hi_nib   <= '0;
      live_en  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: lo_byte  <= wr_data;
        2'd1: mid_byte <= wr_data;
        2'd2: begin
          hi_nib  <= wr_data[7:4];
          live_en <= wr_data[0];
        end
        default: ;
      endcase
    end
  end

  // Line-start copy: the word in flight never changes mid-line.
  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else if (capture) shadow <= {hi_nib, mid_byte, lo_byte};
  end
endmodule

// File: rtl/cgms_seq.sv
module cgms_seq
  import cgms_pkg::*;
#(
  parameter int LEAD_CLKS = 302,
  parameter int CELL_CLKS = 63,
  parameter int NCELLS    = 21,
  localparam int LEAD_W   = (LEAD_CLKS > 1) ? $clog2(LEAD_CLKS) : 1,
  localparam int SUB_W    = (CELL_CLKS > 1) ? $clog2(CELL_CLKS) : 1,
  localparam int CELL_W   = $clog2(NCELLS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              go,
  output logic              in_train,
  output logic [CELL_W-1:0] cell_idx
);
  localparam logic [LEAD_W-1:0] LEAD_LAST = LEAD_W'(LEAD_CLKS - 1);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(CELL_CLKS - 1);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(NCELLS - 1);

  seq_state_t        st;
  logic [LEAD_W-1:0] lead_cnt;
  logic [SUB_W-1:0]  sub_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      lead_cnt <= '0;
      sub_cnt  <= '0;
      cell_idx <= '0;
    end else if (start) begin
      st       <= go ? SQ_LEAD : SQ_IDLE;
      lead_cnt <= '0;
      sub_cnt  <= '0;
      cell_idx <= '0;
    end else begin
      case (st)
        SQ_LEAD: begin
          if (lead_cnt == LEAD_LAST) begin
            st       <= SQ_TRAIN;
            sub_cnt  <= '0;
            cell_idx <= '0;
          end else begin
            lead_cnt <= lead_cnt + 1'b1;
          end
        end
        SQ_TRAIN: begin
          if (sub_cnt == SUB_LAST) begin
            sub_cnt <= '0;
            if (cell_idx == CELL_LAST) st <= SQ_IDLE;
            else cell_idx <= cell_idx + 1'b1;
          end else begin
            sub_cnt <= sub_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_train = (st == SQ_TRAIN);
endmodule

// File: rtl/cgms_level.sv
module cgms_level
  import cgms_pkg::*;
#(
  parameter int LVL_W     = 10,
  parameter int LVL_BLACK = 240,
  parameter int LVL_ONE   = 740,
  localparam int NCELLS   = PAYLOAD_BITS + 1,
  localparam int CELL_W   = $clog2(NCELLS)
)(
  input  logic                    in_train,
  input  logic [CELL_W-1:0]       cell_idx,
  input  logic [PAYLOAD_BITS-1:0] shadow,
  output logic                    insert,
  output logic [LVL_W-1:0]        luma
);
  logic [NCELLS-1:0] cells;
  logic              cur_bit;

  // Cell 0 is the fixed reference; cell k carries payload bit k.
  assign cells = {shadow, 1'b1};

  always_comb begin
    cur_bit = 1'b0;
    for (int k = 0; k < NCELLS; k++)
      if (cell_idx == CELL_W'(k)) cur_bit = cells[k];
  end

  assign insert = in_train;
  assign luma   = (in_train && cur_bit) ? LVL_W'(LVL_ONE) : LVL_W'(LVL_BLACK);
endmodule

// File: rtl/cgms_line_enc.sv
module cgms_line_enc
  import cgms_pkg::*;
#(
  parameter int LINE_W    = 10,
  parameter int LINE_F1   = 20,
  parameter int LINE_F2   = 283,
  parameter int LEAD_CLKS = 302,
  parameter int CELL_CLKS = 63,
  parameter int LVL_W     = 10,
  parameter int LVL_BLACK = 240,
  parameter int LVL_ONE   = 740
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  h_ref,
  input  logic [LINE_W-1:0]     line_num,
  input  logic                  wr_en,
  input  logic [HOST_AW-1:0]    wr_addr,
  input  logic [HOST_DW-1:0]    wr_data,
  output logic                  insert,
  output logic [LVL_W-1:0]      luma
);
  localparam int NCELLS = PAYLOAD_BITS + 1;
  localparam int CELL_W = $clog2(NCELLS);

  logic                    on_target;
  logic                    live_en;
  logic [PAYLOAD_BITS-1:0] shadow;
  logic                    in_train;
  logic [CELL_W-1:0]       cell_idx;

  assign on_target = (line_num == LINE_W'(LINE_F1)) || (line_num == LINE_W'(LINE_F2));

  cgms_hostregs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .capture (h_ref && on_target),
    .live_en (live_en),
    .shadow  (shadow)
  );

  cgms_seq #(
    .LEAD_CLKS (LEAD_CLKS),
    .CELL_CLKS (CELL_CLKS),
    .NCELLS    (NCELLS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (h_ref),
    .go       (on_target && live_en),
    .in_train (in_train),
    .cell_idx (cell_idx)
  );

  cgms_level #(
    .LVL_W     (LVL_W),
    .LVL_BLACK (LVL_BLACK),
    .LVL_ONE   (LVL_ONE)
  ) u_level (
    .in_train (in_train),
    .cell_idx (cell_idx),
    .shadow   (shadow),
    .insert   (insert),
    .luma     (luma)
  );
endmodule

// File: rtl/cgms_line_enc_chk.sv
module cgms_line_enc_chk #(
  parameter int LVL_W     = 10,
  parameter int LVL_BLACK = 240,
  parameter int LVL_ONE   = 740,
  parameter int LEAD_CLKS = 302,
  parameter int CELL_CLKS = 63,
  localparam int TOTAL    = 21 * CELL_CLKS,
  localparam int RUN_W    = $clog2(TOTAL + 2),
  localparam int POS_W    = $clog2(LEAD_CLKS + TOTAL + 2)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             h_ref,
  input logic             insert,
  input logic [LVL_W-1:0] luma
);
  logic [RUN_W-1:0] run;
  logic [POS_W-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (insert) run <= run + 1'b1;
    else run <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) since <= '1;
    else if (h_ref) since <= '0;
    else if (since != '1) since <= since + 1'b1;
  end

  // R7
  idle_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insert |-> luma == LVL_W'(LVL_BLACK));

  // R6
  two_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insert |-> (luma == LVL_W'(LVL_BLACK) || luma == LVL_W'(LVL_ONE)));

  // R4
  ref_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(insert) |-> luma == LVL_W'(LVL_ONE));

  // R3
  train_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(insert) |-> since == POS_W'(LEAD_CLKS));

  // R3
  train_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(insert) && !$past(h_ref)) |-> run == RUN_W'(TOTAL));
endmodule

bind cgms_line_enc cgms_line_enc_chk #(
  .LVL_W     (LVL_W),
  .LVL_BLACK (LVL_BLACK),
  .LVL_ONE   (LVL_ONE),
  .LEAD_CLKS (LEAD_CLKS),
  .CELL_CLKS (CELL_CLKS)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .h_ref  (h_ref),
  .insert (insert),
  .luma   (luma)
);

// File: tb/sim_cgms_line_enc.sv
module sim_cgms_line_enc;
  localparam int CLK_PERIOD = 38;
  localparam int LINE_LEN   = 1716;
  localparam int LEAD       = 302;
  localparam int CELL       = 63;
  localparam int TOTAL      = 21 * CELL;
  localparam int BLACK      = 240;
  localparam int ONE        = 740;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       h_ref = 1'b0;
  logic [9:0] line_num = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       insert;
  logic [9:0] luma;

  cgms_line_enc u0 (
    .clk(clk), .rst_n(rst_n), .h_ref(h_ref), .line_num(line_num),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .insert(insert), .luma(luma)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Behavioural reference: register file, line-start copy, position counter.
  logic [7:0]  m_r0, m_r1;
  logic [3:0]  m_hi;
  logic        m_en;
  logic        m_act;
  logic [19:0] m_sh;
  int          m_p;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r0 = 0; m_r1 = 0; m_hi = 0; m_en = 0; m_act = 0; m_sh = 0; m_p = 100000;
    end else begin
      if (h_ref) begin
        m_act = ((line_num == 10'd20) || (line_num == 10'd283)) && m_en;
        if ((line_num == 10'd20) || (line_num == 10'd283)) m_sh = {m_hi, m_r1, m_r0};
        m_p = 0;
      end else if (m_p < 100000) begin
        m_p++;
      end
      if (wr_en) begin
        if (wr_addr == 2'd0) m_r0 = wr_data;
        else if (wr_addr == 2'd1) m_r1 = wr_data;
        else if (wr_addr == 2'd2) begin m_hi = wr_data[7:4]; m_en = wr_data[0]; end
      end
    end
  end

  int cnt_ins  = 0;
  int cnt_high = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int  exp_ins;
      int  exp_luma;
      int  cidx;
      bit  b;
      string tag;
      exp_ins  = (m_act && m_p >= LEAD && m_p < LEAD + TOTAL) ? 1 : 0;
      exp_luma = BLACK;
      tag      = "R7";
      if (exp_ins == 1) begin
        cidx = (m_p - LEAD) / CELL;
        b    = (cidx == 0) ? 1'b1 : m_sh[cidx - 1];
        exp_luma = b ? ONE : BLACK;
        tag = (cidx == 0) ? "R4" : "R5";
      end
      if (int'(insert) != exp_ins) tag = "R3";
      vectors++;
      if (int'(insert) != exp_ins || int'(luma) != exp_luma) begin
        fails++;
        $display("FAIL %s p=%0d insert=%0d/%0d luma=%0d expected %0d",
                 tag, m_p, insert, exp_ins, luma, exp_luma);
      end
      if (insert) cnt_ins++;
      if (insert && luma == 10'(ONE)) cnt_high++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  int line_ins, line_high;

  // One line: strobe at i=0, optional host write at i=wr_at.
  task automatic run_line(input int ln, input int len, input int wr_at,
                          input logic [1:0] a, input logic [7:0] d);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      h_ref    = (i == 0);
      line_num = 10'(ln);
      wr_en    = (i == wr_at);
      wr_addr  = a;
      wr_data  = d;
      if (i == 1) begin cnt_ins = 0; cnt_high = 0; end
    end
    #1;
    line_ins  = cnt_ins;
    line_high = cnt_high;
    wr_en = 1'b0;
  endtask

  function automatic int hi_for(input logic [19:0] pl);
    return CELL * (1 + $countones(pl));
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", int'(insert), 0);
    chk("R1", int'(luma), BLACK);
    rst_n = 1'b1;
    run_line(20, LINE_LEN, -1, 0, 0);
    chk("R1", line_ins, 0);

    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'hB1);
    run_line(19, LINE_LEN, -1, 0, 0);
    chk("R2", line_ins, 0);
    run_line(20, LINE_LEN, -1, 0, 0);
    chk("R3", line_ins, TOTAL);
    chk("R6", line_high, hi_for(20'hB3CA5));
    run_line(21, LINE_LEN, -1, 0, 0);
    chk("R2", line_ins, 0);
    run_line(283, LINE_LEN, -1, 0, 0);
    chk("R2", line_ins, TOTAL);

    wr(2'd3, 8'hFF); wr(2'd2, 8'h0F);
    run_line(283, LINE_LEN, -1, 0, 0);
    chk("R5", line_high, hi_for(20'h03CA5));

    run_line(20, LINE_LEN, 500, 2'd0, 8'h00);
    chk("R8", line_high, hi_for(20'h03CA5));
    run_line(283, LINE_LEN, -1, 0, 0);
    chk("R8", line_high, hi_for(20'h03C00));
    run_line(20, LINE_LEN, 0, 2'd1, 8'hFF);
    chk("R8", line_high, hi_for(20'h03C00));

    run_line(20, 700, -1, 0, 0);
    chk("R9", line_ins, 700 - 1 - LEAD);
    run_line(283, LINE_LEN, -1, 0, 0);
    chk("R9", line_ins, TOTAL);

    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hF1);
    run_line(20, LINE_LEN, -1, 0, 0);
    chk("R6", line_high, TOTAL);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    run_line(283, LINE_LEN, -1, 0, 0);
    chk("R4", line_high, CELL);

    wr(2'd2, 8'hF0);
    run_line(20, LINE_LEN, -1, 0, 0);
    chk("R10", line_ins, 0);
    chk("R7", int'(luma), BLACK);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule